// File: doc/BRIEF.md
# Damped Two-Integrator Sine Oscillator

This block is a sample-rate digital resonator. It keeps two saturating signed accumulators. The first holds a velocity and the second holds the wave value. On every sample strobe the velocity takes in a negative acceleration: the wave value scaled by an unsigned frequency coefficient. A velocity-squared term is also removed from the velocity. The wave value then integrates the new velocity, minus a small leak proportional to the wave value itself. That leak damps the loop and draws any DC offset back to zero. While the trigger input is high, a fixed kick in the direction of the current velocity pumps energy into the loop. The velocity-squared loss grows faster than the kick, so the amplitude settles to a bounded steady state. Once the trigger drops, the ringing dies away.

All scaled products are rounded by adding pseudo-random dither below the least significant kept bit and then truncating. The dither comes from a small LFSR that steps once per sample. The output sample is the new wave value times a gain, rounded the same way. The gain is the user level multiplied by the square root of the frequency coefficient. The wave amplitude falls roughly as one over the angular frequency, and this square-root factor cancels that, so the output level does not depend on the frequency setting. A level of zero closes the gate.

Samples leave on a valid/ready stream. The oscillator is driven by the strobe and cannot stall, so the stream is lossy. `out_valid` rises after each strobe and stays high until a cycle with `out_ready` high and no new strobe. While it waits, `out_data` is held. A strobe that arrives while the previous sample is still unaccepted replaces that sample.

Top module: `damped_sine_osc`

## Requirements
- R1: A synchronous `rst` clears velocity, wave value, `out_valid` and `out_data` to zero and loads the dither LFSR with the value 1.
- R2: On a strobe the velocity becomes clamp(v - rnd(p*F) - rnd(q*D2) + kick). Here p and v are the stored wave value and velocity, F is `freq_coef` as unsigned Q1.17, q = (v*|v|) >>> 23, and D2 is a Q1.17 parameter (default 4096).
- R3: On the same strobe the wave value becomes clamp(p + v' - rnd(p*D1)), where v' is the new velocity and D1 is a Q1.17 parameter (default 128).
- R4: When `trigger` is high during a strobe, kick = +KICK if v >= 0 and -KICK if v < 0 (KICK defaults to 256). Otherwise kick = 0.
- R5: rnd(x) = floor((x + d) / 2^17), where d is bits 16..0 of a 20-bit LFSR. The LFSR shifts left once per strobe, after use, taking in bit19 XOR bit16 as its new bit 0.
- R6: The output sample is clamp(rnd(p'*G)), with G = floor(L*C / 2^17), L = `level` as unsigned Q1.17, and C = floor(sqrt(F*2^17)).
- R7: A strobe with `level` = 0 produces an output sample of 0.
- R8: Every clamp limits a value to the signed 24-bit range [-2^23, 2^23-1]. The accumulators saturate there instead of wrapping.
- R9: Without a strobe, velocity, wave value and LFSR keep their values, whatever the other inputs do.
- R10: `out_valid` is 1 after every strobe edge and drops after an edge with `out_ready`=1 and no strobe. While it is high and not accepted, `out_data` holds. A new strobe overwrites it.
- R11: After the trigger is released, the peak output over a later window of samples is smaller than the peak over an earlier window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| sample_en | input | 1 | One-cycle sample strobe |
| trigger | input | 1 | Energy injection enable |
| freq_coef | input | 18 | Frequency coefficient, unsigned Q1.17 |
| level | input | 18 | Output level, unsigned Q1.17 |
| out_ready | input | 1 | Downstream accepts sample |
| out_valid | output | 1 | Output sample present |
| out_data | output | 24 | Signed output sample |

## Verification
The new state, `out_valid` and `out_data` all appear on the same rising edge that sees `sample_en` high, so each sample is due exactly one edge after its strobe. The bench raises the strobe at a falling edge. It lets one rising edge pass and reads the outputs at the following falling edge, comparing them with a step-by-step model written from the requirements. For the stream hold and the frozen-state checks, the bench idles several edges without a strobe before it reads. A reading taken then would catch any change made on an edge with no strobe.

// File: rtl/osc_pkg.sv
package osc_pkg;
  typedef logic signed [63:0] wide_t;

  // Clamp a wide value to a signed field of w bits.
  function automatic wide_t clamp_to(input wide_t v, input int w);
    wide_t hi;
    wide_t lo;
    hi = (wide_t'(1) <<< (w - 1)) - wide_t'(1);
    lo = -(wide_t'(1) <<< (w - 1));
    if (v > hi) return hi;
    if (v < lo) return lo;
    return v;
  endfunction

  // Add dither below the kept bits, then drop sh bits (floor).
  function automatic wide_t dither_round(input wide_t p, input wide_t d, input int sh);
    return (p + d) >>> sh;
  endfunction

  // Integer square root by bit-wise trial, nbits result bits.
  function automatic wide_t int_sqrt(input wide_t x, input int nbits);
    wide_t r;
    wide_t t;
    r = '0;
    for (int b = nbits - 1; b >= 0; b--) begin
      t = r | (wide_t'(1) <<< b);
      if (t * t <= x) r = t;
    end
    return r;
  endfunction
endpackage

// File: rtl/osc_dither.sv
module osc_dither #(
  parameter int LW   = 20,
  parameter int TAP  = 16,
  parameter int DW   = 17
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          step,
  output logic [DW-1:0] dither
);
  logic [LW-1:0] state;

  always_ff @(posedge clk) begin
    if (rst) state <= LW'(1);
    else if (step) state <= {state[LW-2:0], state[LW-1] ^ state[TAP]};
  end

  assign dither = state[DW-1:0];

  // R5: the generator never locks up in the all-zero state
  p_lfsr_live_r5: assert property (@(posedge clk) disable iff (rst) state != '0);
  // R9: no step without a strobe
  p_lfsr_hold_r9: assert property (@(posedge clk) disable iff (rst) !step |=> $stable(state));
endmodule

// File: rtl/osc_core.sv
module osc_core
  import osc_pkg::*;
#(
  parameter int W    = 24,
  parameter int CW   = 18,
  parameter int FRAC = 17,
  parameter int D1   = 128,
  parameter int D2   = 4096,
  parameter int KICK = 256
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                sample_en,
  input  logic                trigger,
  input  logic [CW-1:0]       freq_coef,
  input  logic [FRAC-1:0]     dither,
  output logic signed [W-1:0] wave_next
);
  logic signed [W-1:0] vel_q, pos_q;
  wide_t wv, wp, wd, mag, vsq, f_term, d2_term, leak, kick_v, vel_w, pos_w;

  always_comb begin
    wv      = wide_t'(vel_q);
    wp      = wide_t'(pos_q);
    wd      = wide_t'(dither);
    mag     = (vel_q < 0) ? -wv : wv;
    vsq     = (wv * mag) >>> (W - 1);
    f_term  = dither_round(wp * wide_t'(freq_coef), wd, FRAC);
    d2_term = dither_round(vsq * wide_t'(D2), wd, FRAC);
    kick_v  = '0;
    if (trigger) kick_v = (vel_q < 0) ? -wide_t'(KICK) : wide_t'(KICK);
    vel_w   = clamp_to(wv - f_term - d2_term + kick_v, W);
    leak    = dither_round(wp * wide_t'(D1), wd, FRAC);
    pos_w   = clamp_to(wp + vel_w - leak, W);
  end

  assign wave_next = pos_w[W-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      vel_q <= '0;
      pos_q <= '0;
    end else if (sample_en) begin
      vel_q <= vel_w[W-1:0];
      pos_q <= pos_w[W-1:0];
    end
  end

  // R9: state is frozen between strobes
  p_state_frozen_r9: assert property (@(posedge clk) disable iff (rst)
    !sample_en |=> ($stable(vel_q) && $stable(pos_q)));
  // R3: the stored wave value is the one offered downstream on the strobe
  p_wave_commit_r3: assert property (@(posedge clk) disable iff (rst)
    sample_en |=> pos_q == $past(wave_next));
endmodule

// File: rtl/osc_out_stage.sv
module osc_out_stage
  import osc_pkg::*;
#(
  parameter int W    = 24,
  parameter int CW   = 18,
  parameter int FRAC = 17
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                sample_en,
  input  logic signed [W-1:0] wave,
  input  logic [CW-1:0]       freq_coef,
  input  logic [CW-1:0]       level,
  input  logic [FRAC-1:0]     dither,
  input  logic                out_ready,
  output logic                out_valid,
  output logic [W-1:0]        out_data
);
  localparam int RW = CW + 1;
  wide_t comp, gain, res;

  always_comb begin
    comp = int_sqrt(wide_t'(freq_coef) <<< FRAC, RW);
    gain = (wide_t'(level) * comp) >>> FRAC;
    res  = clamp_to(dither_round(wide_t'(wave) * gain, wide_t'(dither), FRAC), W);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else if (sample_en) begin
      out_valid <= 1'b1;
      out_data  <= res[W-1:0];
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  p_valid_after_strobe_r10: assert property (@(posedge clk) disable iff (rst)
    sample_en |=> out_valid);
  p_hold_stalled_r10: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready && !sample_en) |=> (out_valid && $stable(out_data)));
  p_gate_closed_r7: assert property (@(posedge clk) disable iff (rst)
    (sample_en && level == '0) |=> out_data == '0);
endmodule

// File: rtl/damped_sine_osc.sv
module damped_sine_osc #(
  parameter int W    = 24,
  parameter int CW   = 18,
  parameter int FRAC = 17,
  parameter int LW   = 20,
  parameter int TAP  = 16,
  parameter int D1   = 128,
  parameter int D2   = 4096,
  parameter int KICK = 256
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          sample_en,
  input  logic          trigger,
  input  logic [CW-1:0] freq_coef,
  input  logic [CW-1:0] level,
  input  logic          out_ready,
  output logic          out_valid,
  output logic [W-1:0]  out_data
);
  logic [FRAC-1:0]     dither;
  logic signed [W-1:0] wave_next;

  osc_dither #(.LW(LW), .TAP(TAP), .DW(FRAC)) u_dither (
    .clk(clk), .rst(rst), .step(sample_en), .dither(dither)
  );

  osc_core #(.W(W), .CW(CW), .FRAC(FRAC), .D1(D1), .D2(D2), .KICK(KICK)) u_core (
    .clk(clk), .rst(rst), .sample_en(sample_en), .trigger(trigger),
    .freq_coef(freq_coef), .dither(dither), .wave_next(wave_next)
  );

  osc_out_stage #(.W(W), .CW(CW), .FRAC(FRAC)) u_out (
    .clk(clk), .rst(rst), .sample_en(sample_en), .wave(wave_next),
    .freq_coef(freq_coef), .level(level), .dither(dither),
    .out_ready(out_ready), .out_valid(out_valid), .out_data(out_data)
  );
endmodule

// File: tb/damped_sine_osc_bench.sv
`timescale 1ns/1ps
module damped_sine_osc_bench;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sample_en = 1'b0;
  logic trigger = 1'b0;
  logic [17:0] freq_coef = '0;
  logic [17:0] level = '0;
  logic out_ready = 1'b1;
  logic out_valid, sat_valid;
  logic signed [23:0] out_data, sat_data;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  damped_sine_osc u_damped_sine_osc (
    .clk(clk), .rst(rst), .sample_en(sample_en), .trigger(trigger),
    .freq_coef(freq_coef), .level(level), .out_ready(out_ready),
    .out_valid(out_valid), .out_data(out_data)
  );

  damped_sine_osc #(.D1(0), .D2(0), .KICK(2097152)) u_damped_sine_osc_sat (
    .clk(clk), .rst(rst), .sample_en(sample_en), .trigger(trigger),
    .freq_coef(freq_coef), .level(level), .out_ready(out_ready),
    .out_valid(sat_valid), .out_data(sat_data)
  );

  // Reference state written from the requirements
  longint mv, mp, ml, mout;

  function automatic longint lim(input longint x);
    if (x > 8388607) return 8388607;
    if (x < -8388608) return -8388608;
    return x;
  endfunction

  function automatic longint root(input longint x);
    longint r = 0;
    for (int b = 20; b >= 0; b--) begin
      longint t = r | (longint'(1) << b);
      if (t * t <= x) r = t;
    end
    return r;
  endfunction

  task automatic model_reset();
    mv = 0; mp = 0; ml = 1; mout = 0;
  endtask

  task automatic model_step(input longint f, input longint l, input bit trg);
    longint d, a, q, k, g;
    d = ml & 131071;
    a = (mv < 0) ? -mv : mv;
    q = (mv * a) >>> 23;
    k = trg ? ((mv < 0) ? -256 : 256) : 0;
    mv = lim(mv - ((mp * f + d) >>> 17) - ((q * 4096 + d) >>> 17) + k);
    mp = lim(mp + mv - ((mp * 128 + d) >>> 17));
    g = (l * root(f << 17)) >>> 17;
    mout = lim((mp * g + d) >>> 17);
    ml = ((ml << 1) | (((ml >> 19) ^ (ml >> 16)) & 1)) & 20'hFFFFF;
  endtask

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1; sample_en = 1'b0;
    @(negedge clk); @(negedge clk); rst = 1'b0;
    model_reset();
  endtask

  // One strobe; outputs read at the falling edge after the strobe edge
  task automatic strobe(input bit trg, input string tag);
    @(negedge clk);
    trigger = trg; sample_en = 1'b1;
    model_step(longint'(freq_coef), longint'(level), trg);
    @(negedge clk);
    sample_en = 1'b0;
    check(out_valid === 1'b1, "R10 valid", longint'(out_valid), 1);
    check(longint'(out_data) == mout, tag, longint'(out_data), mout);
  endtask

  typedef struct packed {
    logic [17:0] f;
    logic [17:0] lvl;
    logic        trg;
    logic [15:0] n;
  } vec_t;

  localparam vec_t VEC [6] = '{
    '{f: 18'd1310, lvl: 18'd131072, trg: 1'b1, n: 16'd300},
    '{f: 18'd1310, lvl: 18'd131072, trg: 1'b0, n: 16'd150},
    '{f: 18'd5243, lvl: 18'd131072, trg: 1'b1, n: 16'd300},
    '{f: 18'd5243, lvl: 18'd65536,  trg: 1'b1, n: 16'd100},
    '{f: 18'd5243, lvl: 18'd0,      trg: 1'b1, n: 16'd50},
    '{f: 18'd20000, lvl: 18'd131072, trg: 1'b1, n: 16'd150}
  };

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    longint pk1, pk2, hold;
    do_reset();
    // R1: reset state at the ports
    check(out_valid === 1'b0, "R1 valid after reset", longint'(out_valid), 0);
    check(out_data === 24'sd0, "R1 data after reset", longint'(out_data), 0);

    // Table walk: R2 R3 R4 R5 R6 checked sample by sample, R7 in the level-0 row
    for (int i = 0; i < 6; i++) begin
      freq_coef = VEC[i].f; level = VEC[i].lvl;
      for (int s = 0; s < int'(VEC[i].n); s++) begin
        strobe(VEC[i].trg, VEC[i].lvl == 0 ? "R7 gate" :
               (VEC[i].trg ? "R2 R3 R4 R5 R6 kick" : "R2 R3 R5 R6 free"));
        if (VEC[i].lvl == 0) check(out_data == 0, "R7 zero", longint'(out_data), 0);
      end
    end

    // R9: idle with toggling inputs, state must not move
    freq_coef = 18'd5243; level = 18'd131072;
    @(negedge clk); trigger = 1'b1; freq_coef = 18'd99999;
    repeat (12) @(negedge clk);
    trigger = 1'b0; freq_coef = 18'd5243;
    strobe(1'b0, "R9 frozen");

    // R10: stall, overwrite, hold, then accept
    out_ready = 1'b0;
    strobe(1'b0, "R10 first");
    strobe(1'b0, "R10 overwrite");
    hold = longint'(out_data);
    repeat (5) @(negedge clk);
    check(out_valid === 1'b1, "R10 held valid", longint'(out_valid), 1);
    check(longint'(out_data) == hold, "R10 held data", longint'(out_data), hold);
    out_ready = 1'b1;
    @(negedge clk);
    check(out_valid === 1'b0, "R10 drop after accept", longint'(out_valid), 0);

    // R11: decay after release
    pk1 = 0; pk2 = 0;
    for (int s = 0; s < 600; s++) begin
      strobe(1'b0, "R11 decay model");
      if (s < 100 && (out_data > pk1 || -out_data > pk1)) pk1 = (out_data < 0) ? -longint'(out_data) : longint'(out_data);
      if (s >= 500 && (out_data > pk2 || -out_data > pk2)) pk2 = (out_data < 0) ? -longint'(out_data) : longint'(out_data);
    end
    check(pk2 < pk1 && pk1 > 0, "R11 later peak below earlier", pk2, pk1);

    // R8: large-kick instance saturates; wave pinned at 2^23-1, gain 362
    do_reset();
    freq_coef = 18'd1; level = 18'd131072;
    for (int s = 0; s < 10; s++) strobe(1'b1, "R8 R2 small f");
    check(sat_data >= 24'sd23167 && sat_data <= 24'sd23168, "R8 saturated output",
          longint'(sat_data), 23167);
    @(negedge clk); sample_en = 1'b1;
    @(negedge clk); sample_en = 1'b0;
    check(sat_data >= 24'sd23167 && sat_data <= 24'sd23168, "R8 still saturated",
          longint'(sat_data), 23167);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule